// File: doc/BRIEF.md
# PUF Key Regeneration Gate

This block rebuilds a device key from a physical unclonable function and decides whether that key may be handed on. After a start pulse it reads a header word from external non-volatile memory at a programmable base address. The header gives the number of challenge words and the number of helper words. The block then fetches the challenge words and the helper words and passes them, one handshake at a time, to an external PUF key-reconstruction port. It also fetches a stored 256-bit integrity-check value.

Once the PUF returns the regenerated key, the block hands the key to an external hash unit. It compares the returned digest with the stored value. If they match, the key goes straight to the cipher engine's key port, marked by a one-cycle strobe, and the internal copy is wiped. If they differ, the block wipes its key state and raises a deactivate line for the processor subsystem. It stays locked until the next reset. A header that asks for more words than the block supports also leads to the lock.

Top module: `keygate_top`

## Requirements
- R1: While `rst` is high, all outputs are driven to zero on the next clock edge: `ck_valid`, `ck_key`, `deactivate`, `mem_req`, `puf_valid`, `puf_go`, `hash_req` and `hash_msg`.
- R2: A `start` pulse in the idle state reads the header at `base_addr`. Header bits [15:0] hold the challenge count and bits [31:16] hold the helper count. The challenge words are read from `base_addr+1` upward, the helper words follow, and then 8 check words are read, where check word j holds digest bits [32j+31:32j]. Each word is read exactly once per run.
- R3: If either header count exceeds `MAX_WORDS`, the block raises `deactivate` and issues no further memory read.
- R4: The block offers every challenge word to the PUF with `puf_helper`=0, then every helper word with `puf_helper`=1, in address order. While `puf_ready` is low, `puf_valid`, `puf_word` and `puf_helper` hold.
- R5: `puf_go` pulses for one cycle, and only after the PUF has accepted the last word. The key is taken from `puf_key` in the cycle `puf_key_valid` is high.
- R6: The regenerated key is placed on `hash_msg`, with `hash_req` held until `hash_ack`. The digest on `hash_digest` is compared over all 256 bits with the stored check value.
- R7: On a match, `ck_valid` is high for exactly one cycle and `ck_key` carries the regenerated key. `ck_key` is zero in every other cycle.
- R8: On a mismatch, `deactivate` rises and stays high until reset, and `ck_valid` never rises.
- R9: `start` is ignored while a run is in progress and while the block is locked.
- R10: A count of zero skips its phase. The remaining words are still read from consecutive addresses.
- R11: The internal key register, which is visible on `hash_msg`, is zero after a release and after entry to the lock.
- R12: At most one memory read is outstanding. `mem_req` is a single-cycle pulse, and it does not rise again before the previous `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| start | input | 1 | Begins a regeneration run when idle |
| base_addr | input | AW | Word address of the header |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | AW | Memory read word address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| puf_valid | output | 1 | Word offered to the PUF |
| puf_helper | output | 1 | 0 marks a challenge word, 1 marks a helper word |
| puf_word | output | DW | Challenge or helper word |
| puf_ready | input | 1 | PUF accepts the offered word |
| puf_go | output | 1 | One-cycle command to reconstruct the key |
| puf_key_valid | input | 1 | Reconstructed key present |
| puf_key | input | KEY_W | Reconstructed key |
| hash_req | output | 1 | Hash request, held until acknowledged |
| hash_msg | output | KEY_W | Key to be hashed |
| hash_ack | input | 1 | Digest present |
| hash_digest | input | KEY_W | Digest of `hash_msg` |
| ck_valid | output | 1 | One-cycle key strobe to the cipher engine |
| ck_key | output | KEY_W | Key for the cipher engine |
| deactivate | output | 1 | Shuts down the processor subsystem |

## Verification
The hardest case to reach is a check value that differs from the digest in a single bit of its last word. It comes up only after a complete, correct fetch and reconstruction. The bench prepares memory contents whose stored value is the true digest with its top bit flipped, and it checks that the run ends in the lock with no key strobe and a wiped key. The bench then pulses `start` while the block is locked and counts memory reads, to show that the lock ignores `start`. Other runs apply PUF back-pressure, use several memory latencies and zero counts, and pulse `start` again in the middle of a fetch.

// File: rtl/keygate_pkg.sv
package keygate_pkg;

  typedef enum logic [3:0] {
    KG_IDLE,
    KG_HDR,
    KG_CHAL,
    KG_HELP,
    KG_REF,
    KG_REGEN,
    KG_CHECK,
    KG_RELEASE,
    KG_LOCK
  } kg_state_e;

  // header layout: challenge count low, helper count high
  localparam int unsigned HDR_FIELD_W = 16;

endpackage

// File: rtl/keygate_memrd.sv
module keygate_memrd #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          rd_done,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b0;
      mem_addr <= '0;
      rd_done  <= 1'b0;
      rd_data  <= '0;
    end else begin
      mem_req <= rd_go;
      if (rd_go) mem_addr <= rd_addr;
      rd_done <= mem_rvalid;
      if (mem_rvalid) rd_data <= mem_rdata;
    end
  end

endmodule

// File: rtl/keygate_ctrl.sv
module keygate_ctrl
  import keygate_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 32,
  parameter int unsigned MAX_WORDS = 64,
  parameter int unsigned REF_WORDS = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [AW-1:0]          base_addr,
  output logic                   rd_go,
  output logic [AW-1:0]          rd_addr,
  input  logic                   rd_done,
  input  logic [DW-1:0]          rd_data,
  output logic                   puf_valid,
  output logic                   puf_helper,
  output logic [DW-1:0]          puf_word,
  input  logic                   puf_ready,
  output logic                   puf_go,
  input  logic                   puf_key_valid,
  output logic                   hash_req,
  input  logic                   hash_ack,
  input  logic                   digest_match,
  output logic                   key_load,
  output logic                   ref_we,
  output logic [HDR_FIELD_W-1:0] ref_idx,
  output logic                   rel_pulse,
  output logic                   wipe,
  output logic                   deactivate
);

  localparam logic [HDR_FIELD_W-1:0] CNT_MAX  = HDR_FIELD_W'(MAX_WORDS);
  localparam logic [HDR_FIELD_W-1:0] REF_LAST = HDR_FIELD_W'(REF_WORDS);

  kg_state_e              state;
  logic                   pend;
  logic [HDR_FIELD_W-1:0] idx;
  logic [HDR_FIELD_W-1:0] chal_cnt;
  logic [HDR_FIELD_W-1:0] help_cnt;
  logic [HDR_FIELD_W-1:0] cnt_cur;
  logic [AW-1:0]          cur_addr;
  logic [HDR_FIELD_W-1:0] hdr_chal;
  logic [HDR_FIELD_W-1:0] hdr_help;

  assign hdr_chal  = rd_data[HDR_FIELD_W-1:0];
  assign hdr_help  = rd_data[2*HDR_FIELD_W-1:HDR_FIELD_W];
  assign cnt_cur   = (state == KG_CHAL) ? chal_cnt : help_cnt;
  assign key_load  = (state == KG_REGEN) && puf_key_valid;
  assign ref_we    = (state == KG_REF) && rd_done;
  assign ref_idx   = idx;
  assign rel_pulse = (state == KG_RELEASE);
  assign wipe      = (state == KG_RELEASE) || (state == KG_LOCK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= KG_IDLE;
      pend       <= 1'b0;
      idx        <= '0;
      chal_cnt   <= '0;
      help_cnt   <= '0;
      cur_addr   <= '0;
      rd_go      <= 1'b0;
      rd_addr    <= '0;
      puf_valid  <= 1'b0;
      puf_helper <= 1'b0;
      puf_word   <= '0;
      puf_go     <= 1'b0;
      hash_req   <= 1'b0;
      deactivate <= 1'b0;
    end else begin
      rd_go  <= 1'b0;
      puf_go <= 1'b0;
      if (puf_valid && puf_ready) puf_valid <= 1'b0;
      case (state)
        KG_IDLE: begin
          if (start) begin
            state    <= KG_HDR;
            rd_go    <= 1'b1;
            rd_addr  <= base_addr;
            cur_addr <= base_addr + AW'(1);
            pend     <= 1'b1;
          end
        end
        KG_HDR: begin
          if (rd_done) begin
            pend     <= 1'b0;
            idx      <= '0;
            chal_cnt <= hdr_chal;
            help_cnt <= hdr_help;
            if (hdr_chal > CNT_MAX || hdr_help > CNT_MAX) begin
              state      <= KG_LOCK;
              deactivate <= 1'b1;
            end else begin
              state <= KG_CHAL;
            end
          end
        end
        KG_CHAL, KG_HELP: begin
          if (rd_done) begin
            pend       <= 1'b0;
            puf_valid  <= 1'b1;
            puf_word   <= rd_data;
            puf_helper <= (state == KG_HELP);
            idx        <= idx + 1'b1;
          end else if (!pend && !puf_valid) begin
            if (idx == cnt_cur) begin
              idx   <= '0;
              state <= (state == KG_CHAL) ? KG_HELP : KG_REF;
            end else begin
              rd_go    <= 1'b1;
              rd_addr  <= cur_addr;
              cur_addr <= cur_addr + AW'(1);
              pend     <= 1'b1;
            end
          end
        end
        KG_REF: begin
          if (rd_done) begin
            pend <= 1'b0;
            idx  <= idx + 1'b1;
          end else if (!pend) begin
            if (idx == REF_LAST) begin
              idx    <= '0;
              state  <= KG_REGEN;
              puf_go <= 1'b1;
            end else begin
              rd_go    <= 1'b1;
              rd_addr  <= cur_addr;
              cur_addr <= cur_addr + AW'(1);
              pend     <= 1'b1;
            end
          end
        end
        KG_REGEN: begin
          if (puf_key_valid) begin
            state    <= KG_CHECK;
            hash_req <= 1'b1;
          end
        end
        KG_CHECK: begin
          if (hash_ack) begin
            hash_req <= 1'b0;
            if (digest_match) begin
              state <= KG_RELEASE;
            end else begin
              state      <= KG_LOCK;
              deactivate <= 1'b1;
            end
          end
        end
        KG_RELEASE: state <= KG_IDLE;
        KG_LOCK:    state <= KG_LOCK;
        default:    state <= KG_LOCK;
      endcase
    end
  end

endmodule

// File: rtl/keygate_vault.sv
module keygate_vault
  import keygate_pkg::*;
#(
  parameter int unsigned KEY_W = 256,
  parameter int unsigned DW    = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   key_load,
  input  logic [KEY_W-1:0]       puf_key,
  input  logic                   ref_we,
  input  logic [HDR_FIELD_W-1:0] ref_idx,
  input  logic [DW-1:0]          ref_word,
  input  logic [KEY_W-1:0]       hash_digest,
  output logic                   digest_match,
  input  logic                   rel_pulse,
  input  logic                   wipe,
  output logic [KEY_W-1:0]       key_q,
  output logic [KEY_W-1:0]       ck_key,
  output logic                   ck_valid
);

  localparam int unsigned REF_WORDS = KEY_W / DW;

  logic [KEY_W-1:0] ref_q;

  assign digest_match = (ref_q == hash_digest);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_q    <= '0;
      ck_key   <= '0;
      ck_valid <= 1'b0;
    end else begin
      ck_valid <= rel_pulse;
      ck_key   <= rel_pulse ? key_q : '0;
      if (wipe)          key_q <= '0;
      else if (key_load) key_q <= puf_key;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wipe) begin
      ref_q <= '0;
    end else if (ref_we) begin
      for (int i = 0; i < REF_WORDS; i++) begin
        if (ref_idx == HDR_FIELD_W'(i)) ref_q[i*DW +: DW] <= ref_word;
      end
    end
  end

endmodule

// File: rtl/keygate_top.sv
module keygate_top
  import keygate_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 32,
  parameter int unsigned KEY_W     = 256,
  parameter int unsigned MAX_WORDS = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             puf_valid,
  output logic             puf_helper,
  output logic [DW-1:0]    puf_word,
  input  logic             puf_ready,
  output logic             puf_go,
  input  logic             puf_key_valid,
  input  logic [KEY_W-1:0] puf_key,
  output logic             hash_req,
  output logic [KEY_W-1:0] hash_msg,
  input  logic             hash_ack,
  input  logic [KEY_W-1:0] hash_digest,
  output logic             ck_valid,
  output logic [KEY_W-1:0] ck_key,
  output logic             deactivate
);

  localparam int unsigned REF_WORDS = KEY_W / DW;

  logic                   rd_go;
  logic [AW-1:0]          rd_addr;
  logic                   rd_done;
  logic [DW-1:0]          rd_data;
  logic                   digest_match;
  logic                   key_load;
  logic                   ref_we;
  logic [HDR_FIELD_W-1:0] ref_idx;
  logic                   rel_pulse;
  logic                   wipe;

  keygate_memrd #(.AW(AW), .DW(DW)) u_memrd (
    .clk(clk), .rst(rst), .rd_go(rd_go), .rd_addr(rd_addr),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rd_done(rd_done), .rd_data(rd_data)
  );

  keygate_ctrl #(
    .AW(AW), .DW(DW), .MAX_WORDS(MAX_WORDS), .REF_WORDS(REF_WORDS)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .rd_go(rd_go), .rd_addr(rd_addr), .rd_done(rd_done), .rd_data(rd_data),
    .puf_valid(puf_valid), .puf_helper(puf_helper), .puf_word(puf_word),
    .puf_ready(puf_ready), .puf_go(puf_go), .puf_key_valid(puf_key_valid),
    .hash_req(hash_req), .hash_ack(hash_ack), .digest_match(digest_match),
    .key_load(key_load), .ref_we(ref_we), .ref_idx(ref_idx),
    .rel_pulse(rel_pulse), .wipe(wipe), .deactivate(deactivate)
  );

  keygate_vault #(.KEY_W(KEY_W), .DW(DW)) u_vault (
    .clk(clk), .rst(rst), .key_load(key_load), .puf_key(puf_key),
    .ref_we(ref_we), .ref_idx(ref_idx), .ref_word(rd_data),
    .hash_digest(hash_digest), .digest_match(digest_match),
    .rel_pulse(rel_pulse), .wipe(wipe), .key_q(hash_msg),
    .ck_key(ck_key), .ck_valid(ck_valid)
  );

endmodule

// File: rtl/keygate_checker.sv
module keygate_checker #(
  parameter int unsigned DW    = 32,
  parameter int unsigned KEY_W = 256
) (
  input logic             clk,
  input logic             rst,
  input logic             mem_req,
  input logic             puf_valid,
  input logic             puf_helper,
  input logic [DW-1:0]    puf_word,
  input logic             puf_ready,
  input logic             puf_go,
  input logic             hash_req,
  input logic             hash_ack,
  input logic [KEY_W-1:0] hash_msg,
  input logic             ck_valid,
  input logic [KEY_W-1:0] ck_key,
  input logic             deactivate
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!ck_valid && !deactivate && !mem_req && !puf_valid && !hash_req));

  p_puf_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (puf_valid && !puf_ready) |=> (puf_valid && $stable(puf_word) && $stable(puf_helper)));

  p_go_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    puf_go |=> !puf_go);

  p_hash_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (hash_req && !hash_ack) |=> (hash_req && $stable(hash_msg)));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    ck_valid |=> !ck_valid);

  p_key_dark_r7: assert property (@(posedge clk) disable iff (rst)
    !ck_valid |-> (ck_key == '0));

  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    deactivate |=> deactivate);

  p_no_release_locked_r8: assert property (@(posedge clk) disable iff (rst)
    deactivate |-> !ck_valid);

  p_one_read_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

endmodule

bind keygate_top keygate_checker #(.DW(DW), .KEY_W(KEY_W)) u_keygate_checker (
  .clk(clk), .rst(rst), .mem_req(mem_req), .puf_valid(puf_valid),
  .puf_helper(puf_helper), .puf_word(puf_word), .puf_ready(puf_ready),
  .puf_go(puf_go), .hash_req(hash_req), .hash_ack(hash_ack),
  .hash_msg(hash_msg), .ck_valid(ck_valid), .ck_key(ck_key),
  .deactivate(deactivate)
);

// File: tb/tb_keygate_top.sv
`timescale 1ns/1ps
module tb_keygate_top;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int KW = 256;
  localparam int MAXW = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          puf_valid, puf_helper, puf_go;
  logic [DW-1:0] puf_word;
  logic          puf_ready = 1'b1;
  logic          puf_key_valid = 1'b0;
  logic [KW-1:0] puf_key = '0;
  logic          hash_req;
  logic [KW-1:0] hash_msg;
  logic          hash_ack = 1'b0;
  logic [KW-1:0] hash_digest = '0;
  logic          ck_valid;
  logic [KW-1:0] ck_key;
  logic          deactivate;

  keygate_top #(.AW(AW), .DW(DW), .KEY_W(KW), .MAX_WORDS(MAXW)) dut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .puf_valid(puf_valid), .puf_helper(puf_helper),
    .puf_word(puf_word), .puf_ready(puf_ready), .puf_go(puf_go),
    .puf_key_valid(puf_key_valid), .puf_key(puf_key), .hash_req(hash_req),
    .hash_msg(hash_msg), .hash_ack(hash_ack), .hash_digest(hash_digest),
    .ck_valid(ck_valid), .ck_key(ck_key), .deactivate(deactivate)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  int reads = 0, ck_cnt = 0, width_err = 0, leak_err = 0;
  int mem_lat = 1;
  bit bp_en = 1'b0;
  bit finished = 1'b0;
  logic [DW-1:0] mem [0:255];
  logic [DW:0]   puf_q [$];
  logic [KW-1:0] key_q [$];
  logic [KW-1:0] exp_hash = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [KW-1:0] act, input logic [KW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] step(input logic [DW-1:0] acc, input logic [DW-1:0] w, input bit f);
    return {acc[DW-2:0], acc[DW-1]} ^ w ^ (f ? 32'h5A5A_5A5A : 32'h0);
  endfunction

  function automatic logic [KW-1:0] mk_key(input logic [DW-1:0] acc);
    logic [KW-1:0] k;
    for (int i = 0; i < KW/DW; i++) k[i*DW +: DW] = acc ^ (32'(i) * 32'h9E37_79B9);
    return k;
  endfunction

  function automatic logic [KW-1:0] hfun(input logic [KW-1:0] m);
    return {m[KW/2-1:0], m[KW-1:KW/2]} ^ {8{32'h3C3C_A5A5}};
  endfunction

  // memory model
  initial begin
    logic [AW-1:0] a;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (mem_req) begin
        a = mem_addr;
        reads++;
        repeat (mem_lat) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = mem[a[7:0]];
      end
    end
  end

  // PUF model and monitor of offered words
  initial begin
    logic [DW-1:0] acc;
    int tick, kwait;
    acc = '0; tick = 0; kwait = 0;
    forever begin
      @(negedge clk);
      puf_key_valid = 1'b0;
      tick++;
      puf_ready = !bp_en || (tick % 3 == 0);
      if (puf_valid && puf_ready) begin
        if (puf_q.size() == 0) begin
          chk(1'b0, "R4", "unexpected puf word", {{(KW-DW-1){1'b0}}, puf_helper, puf_word}, '0);
        end else begin
          logic [DW:0] e;
          e = puf_q.pop_front();
          chk({puf_helper, puf_word} == e, "R4", "puf word/order",
              {{(KW-DW-1){1'b0}}, puf_helper, puf_word}, {{(KW-DW-1){1'b0}}, e});
        end
        acc = step(acc, puf_word, puf_helper);
      end
      if (puf_go) begin
        chk(puf_q.size() == 0, "R5", "go before all words taken", KW'(puf_q.size()), '0);
        kwait = 3;
      end else if (kwait > 0) begin
        kwait--;
        if (kwait == 0) begin
          puf_key_valid = 1'b1;
          puf_key = mk_key(acc);
          acc = '0;
        end
      end
    end
  end

  // hash model
  initial begin
    logic [KW-1:0] m;
    forever begin
      @(negedge clk);
      hash_ack = 1'b0;
      if (hash_req) begin
        m = hash_msg;
        chk(m == exp_hash, "R6", "hash message", m, exp_hash);
        repeat (2) @(negedge clk);
        hash_ack = 1'b1;
        hash_digest = hfun(m);
      end
    end
  end

  // cipher port monitor
  initial begin
    bit prev;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (ck_valid) begin
          if (prev) width_err++;
          ck_cnt++;
          if (key_q.size() == 0) chk(1'b0, "R8", "release not expected", ck_key, '0);
          else begin
            logic [KW-1:0] e;
            e = key_q.pop_front();
            chk(ck_key == e, "R7", "released key", ck_key, e);
          end
        end else if (ck_key != '0) leak_err++;
      end
      prev = ck_valid;
    end
  end

  task automatic do_reset();
    rst = 1'b1; start = 1'b0;
    repeat (3) @(negedge clk);
    chk({ck_valid, deactivate, mem_req, puf_valid, puf_go, hash_req} == 6'b0, "R1",
        "control outputs in reset",
        KW'({ck_valid, deactivate, mem_req, puf_valid, puf_go, hash_req}), '0);
    chk(ck_key == '0 && hash_msg == '0, "R1", "key outputs in reset", ck_key | hash_msg, '0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input logic [7:0] base, input int nc, input int nh, input bit pass,
                          input bit bp, input int lat, input bit restart, input string req);
    logic [DW-1:0] acc, w;
    logic [KW-1:0] key, dig;
    int r0, c0;
    acc = '0;
    mem_lat = lat; bp_en = bp;
    base_addr = AW'(base);
    mem[base] = {16'(nh), 16'(nc)};
    for (int i = 0; i < nc; i++) begin
      w = 32'hC1A0_0000 ^ (32'(base) << 8) ^ (32'(i) * 32'h0101_0037);
      mem[8'(base + 1 + i)] = w;
      puf_q.push_back({1'b0, w});
      acc = step(acc, w, 1'b0);
    end
    for (int i = 0; i < nh; i++) begin
      w = 32'h4E1B_0000 ^ (32'(base) << 4) ^ (32'(i) * 32'h0203_0405);
      mem[8'(base + 1 + nc + i)] = w;
      puf_q.push_back({1'b1, w});
      acc = step(acc, w, 1'b1);
    end
    key = mk_key(acc);
    dig = hfun(key);
    if (!pass) dig[KW-1] = ~dig[KW-1];
    for (int j = 0; j < KW/DW; j++) mem[8'(base + 1 + nc + nh + j)] = dig[j*DW +: DW];
    exp_hash = key;
    if (pass) key_q.push_back(key);
    r0 = reads; c0 = ck_cnt;
    pulse_start();
    if (restart) begin
      repeat (4) @(negedge clk);
      pulse_start();
    end
    for (int n = 0; n < 3000; n++) begin
      if (ck_cnt != c0 || deactivate) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
    chk(reads - r0 == 1 + nc + nh + KW/DW, req, "memory reads per run",
        KW'(reads - r0), KW'(1 + nc + nh + KW/DW));
    chk(hash_msg == '0, "R11", "key register wiped", hash_msg, '0);
    if (pass) begin
      chk(ck_cnt == c0 + 1, "R7", "one release", KW'(ck_cnt - c0), KW'(1));
      chk(!deactivate, "R7", "no deactivate on pass", KW'(deactivate), '0);
    end else begin
      chk(deactivate, "R8", "deactivate on mismatch", KW'(deactivate), KW'(1));
      chk(ck_cnt == c0, "R8", "no release on mismatch", KW'(ck_cnt - c0), '0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog run did not complete act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    do_reset();

    run_case(8'h10, 3, 2, 1'b1, 1'b0, 1, 1'b0, "R2");
    run_case(8'h30, 5, 4, 1'b1, 1'b1, 3, 1'b1, "R9");
    run_case(8'h50, 1, 0, 1'b1, 1'b0, 0, 1'b0, "R10");
    run_case(8'h70, 0, 2, 1'b1, 1'b1, 2, 1'b0, "R10");

    // oversize header
    base_addr = AW'(8'hA0);
    mem[8'hA0] = {16'd1, 16'(MAXW + 1)};
    r0 = reads;
    pulse_start();
    for (int n = 0; n < 200 && !deactivate; n++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(deactivate, "R3", "lock on oversize header", KW'(deactivate), KW'(1));
    chk(reads - r0 == 1, "R3", "header read only", KW'(reads - r0), KW'(1));
    do_reset();
    chk(!deactivate, "R1", "reset leaves lock", KW'(deactivate), '0);

    // single-bit digest mismatch
    run_case(8'hC0, 4, 3, 1'b0, 1'b0, 1, 1'b0, "R2");
    r0 = reads;
    pulse_start();
    repeat (60) @(negedge clk);
    chk(reads == r0, "R9", "start ignored while locked", KW'(reads - r0), '0);
    chk(deactivate, "R8", "lock persists", KW'(deactivate), KW'(1));

    do_reset();
    run_case(8'hE0, 2, 2, 1'b1, 1'b1, 1, 1'b0, "R2");

    chk(width_err == 0, "R7", "strobe width", KW'(width_err), '0);
    chk(leak_err == 0, "R7", "key dark outside strobe", KW'(leak_err), '0);
    chk(puf_q.size() == 0 && key_q.size() == 0, "R4", "scoreboard drained",
        KW'(puf_q.size() + key_q.size()), '0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule